// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits next to a small 8-bit processor core and owns the core's program counter, stack pointer and status byte. Interrupt requests set per-source pending latches. When the core signals an instruction boundary and an eligible source is pending, the block takes over the byte-wide memory port for a fixed eight-cycle entry sequence. In that sequence it turns off further maskable interrupts and clears the chosen latch. It then saves the status byte, which carries the master enable in bit 7, and the return address on a downward-growing stack. Last, it reads a two-byte vector and loads it into the program counter.

A return strobe runs the opposite, four-cycle sequence. It pops the program counter and the status byte, and with the status byte the master enable comes back. Source 0 is non-maskable. It bypasses the master enable, but it cannot nest: it stays blocked until the non-maskable form of return is used. The core loads and reads PC, SP and status through plain strobes when the sequencer is idle.

The memory port is a plain, fixed-latency master. Each machine cycle makes at most one access, and read data comes back one cycle after the read strobe. It has no valid/ready handshake and no back-pressure, because the sequence length must not change. Instruction decode and ALU work belong to the core.

Top module: `intr_accept_seq`

## Requirements
- R1: A high `irq_req[i]` sets pending latch i, which is visible on `irq_pend[i]` one cycle later. The latch stays set until its source is accepted or `irq_clr[i]` clears it. A request in the same cycle as a clear or an acceptance of that source wins, and the latch stays set.
- R2: An acceptance starts only on a cycle where `insn_done` is high, the sequencer is idle and `ret_go` is low. Among the eligible pending sources, the lowest index is picked. Sources 1 and up are eligible only while status bit 7 (the master enable) is 1.
- R3: An entry sequence holds `seq_busy` high for exactly 8 cycles, starting the cycle after the accepting `insn_done`.
- R4: On acceptance, status bit 7 reads 0 from the first busy cycle on. The status byte that is saved is the value from before acceptance, including bit 7.
- R5: Only the latch of the accepted source is cleared. All other pending latches keep their state.
- R6: Busy cycles 0, 1 and 2 write, in that order, the status byte to address SP, PC[15:8] to SP-1 and PC[7:0] to SP-2. SP then reads 3 less than before.
- R7: Busy cycles 3 and 4 read from VEC_BASE+2*i (low byte) and VEC_BASE+2*i+1 (high byte), where VEC_BASE defaults to FFF0h. `mem_rdata` is sampled one cycle after each read strobe. When busy drops, PC holds {high,low}.
- R8: Reset clears PC, SP, status (so the master enable is 0), all latches and the non-maskable-active flag, and leaves the sequencer idle.
- R9: A `ret_go` pulse while idle holds `seq_busy` for 4 cycles. The return reads PC[7:0] from SP+1, PC[15:8] from SP+2 and the status byte from SP+3. SP then reads 3 more than before, and status bit 7 is restored.
- R10: Source 0 is accepted whatever the value of status bit 7, and its acceptance sets `nmi_active`. While `nmi_active` is 1, source 0 is not eligible. Only a return with `ret_nmi`=1 clears `nmi_active`; a return with `ret_nmi`=0 leaves it unchanged.
- R11: `pc_load`, `sp_load` and `st_load` take effect only in idle cycles that start no sequence. While busy, they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Per-source request, sets the latch |
| irq_clr | input | N_SRC | Per-source software clear of the latch |
| irq_pend | output | N_SRC | Pending latch state |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| ret_go | input | 1 | Start the return sequence |
| ret_nmi | input | 1 | With ret_go: 1 selects the non-maskable return form |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data due next cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| pc_load | input | 1 | Load PC from pc_wdata |
| pc_wdata | input | 16 | PC load value |
| pc_q | output | 16 | Program counter |
| sp_load | input | 1 | Load SP from sp_wdata |
| sp_wdata | input | 16 | SP load value |
| sp_q | output | 16 | Stack pointer |
| st_load | input | 1 | Load status from st_wdata |
| st_wdata | input | 8 | Status load value |
| st_q | output | 8 | Status byte, bit 7 is the master enable |
| seq_busy | output | 1 | A sequence owns the memory port |
| nmi_active | output | 1 | A non-maskable service is in progress |

## Verification
The assertions check these rules on every cycle:
- a sequence starts only after a boundary or return strobe;
- the master enable is 0 from the first busy cycle;
- SP moves by exactly 3 at the end of the push and pop phases;
- a new request always leaves its latch set;
- the picker grants at most one source, and only an eligible one;
- memory never sees a read and a write in the same cycle.

Only the bench scenarios can show the following:
- the byte order and addresses on the stack;
- the vector slot chosen for each source, and the PC built from it;
- priority between several pending sources;
- other latches surviving an acceptance;
- non-maskable nesting and its two return forms;
- loads being ignored while busy.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ENTRY, SQ_RET} seq_state_t;
  localparam int ENTRY_LEN = 8;
  localparam int RET_LEN   = 4;
  localparam int CNT_W     = 3;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] acc_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~sw_clr_i & ~acc_clr_i) | set_i;
  end

  assign pend_o = lat_q;

  // R1
  req_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((lat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_SRC = 8,
  localparam int IDW = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic             imf_i,
  input  logic             nmi_blk_i,
  output logic             any_o,
  output logic [IDW-1:0]   id_o,
  output logic [N_SRC-1:0] grant_o
);
  logic [N_SRC-1:0] elig;

  assign elig = pend_i & {{(N_SRC-1){imf_i}}, ~nmi_blk_i};

  always_comb begin
    id_o    = '0;
    grant_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) id_o = IDW'(i);
    end
    any_o = |elig;
    if (any_o) grant_o[id_o] = 1'b1;
  end

  // R2
  always_comb begin
    one_grant_chk: assert ($onehot0(grant_o) && ((grant_o & ~elig) == '0));
  end
endmodule

// File: rtl/intr_accept_seq.sv
module intr_accept_seq
  import intr_seq_pkg::*;
#(
  parameter int          N_SRC    = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFF0,
  parameter int          IMF_BIT  = 7,
  localparam int IDW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_clr,
  output logic [N_SRC-1:0] irq_pend,
  input  logic             insn_done,
  input  logic             ret_go,
  input  logic             ret_nmi,
  output logic [15:0]      mem_addr,
  output logic             mem_we,
  output logic             mem_re,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             pc_load,
  input  logic [15:0]      pc_wdata,
  output logic [15:0]      pc_q,
  input  logic             sp_load,
  input  logic [15:0]      sp_wdata,
  output logic [15:0]      sp_q,
  input  logic             st_load,
  input  logic [7:0]       st_wdata,
  output logic [7:0]       st_q,
  output logic             seq_busy,
  output logic             nmi_active
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [IDW-1:0]   id_q;
  logic [7:0]       st_save, lo_q, hi_q;
  logic [15:0]      pc_r, sp_r, vec_lo;
  logic [7:0]       psw_r;
  logic             nmi_r, ret_kind_q;

  logic             pick_any;
  logic [IDW-1:0]   pick_id;
  logic [N_SRC-1:0] pick_grant, acc_clr;
  logic             idle, accept, rstart;

  irq_latch_bank #(.N_SRC(N_SRC)) u_lat (
    .clk(clk), .rst_n(rst_n), .set_i(irq_req), .sw_clr_i(irq_clr),
    .acc_clr_i(acc_clr), .pend_o(irq_pend)
  );

  irq_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .pend_i(irq_pend), .imf_i(psw_r[IMF_BIT]), .nmi_blk_i(nmi_r),
    .any_o(pick_any), .id_o(pick_id), .grant_o(pick_grant)
  );

  assign idle    = (state == SQ_IDLE);
  assign rstart  = idle && ret_go;
  assign accept  = idle && insn_done && pick_any && !ret_go;
  assign acc_clr = accept ? pick_grant : '0;
  assign vec_lo  = VEC_BASE + (16'(id_q) << 1);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (state == SQ_ENTRY) begin
      case (cnt)
        3'd0: begin mem_we = 1'b1; mem_addr = sp_r;          mem_wdata = st_save;    end
        3'd1: begin mem_we = 1'b1; mem_addr = sp_r - 16'd1;  mem_wdata = pc_r[15:8]; end
        3'd2: begin mem_we = 1'b1; mem_addr = sp_r - 16'd2;  mem_wdata = pc_r[7:0];  end
        3'd3: begin mem_re = 1'b1; mem_addr = vec_lo;                                 end
        3'd4: begin mem_re = 1'b1; mem_addr = vec_lo + 16'd1;                         end
        default: ;
      endcase
    end else if (state == SQ_RET) begin
      case (cnt)
        3'd0: begin mem_re = 1'b1; mem_addr = sp_r + 16'd1; end
        3'd1: begin mem_re = 1'b1; mem_addr = sp_r + 16'd2; end
        3'd2: begin mem_re = 1'b1; mem_addr = sp_r + 16'd3; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;  cnt <= '0;  id_q <= '0;
      st_save <= '0;  lo_q <= '0;  hi_q <= '0;
      pc_r <= '0;  sp_r <= '0;  psw_r <= '0;
      nmi_r <= 1'b0;  ret_kind_q <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (rstart) begin
            state      <= SQ_RET;
            ret_kind_q <= ret_nmi;
          end else if (accept) begin
            state          <= SQ_ENTRY;
            id_q           <= pick_id;
            st_save        <= psw_r;
            psw_r[IMF_BIT] <= 1'b0;
            if (pick_grant[0]) nmi_r <= 1'b1;
          end else begin
            if (pc_load) pc_r  <= pc_wdata;
            if (sp_load) sp_r  <= sp_wdata;
            if (st_load) psw_r <= st_wdata;
          end
        end
        SQ_ENTRY: begin
          cnt <= cnt + 1'b1;
          if (cnt == 3'd2) sp_r <= sp_r - 16'd3;
          if (cnt == 3'd4) lo_q <= mem_rdata;
          if (cnt == 3'd5) pc_r <= {mem_rdata, lo_q};
          if (cnt == CNT_W'(ENTRY_LEN - 1)) state <= SQ_IDLE;
        end
        SQ_RET: begin
          cnt <= cnt + 1'b1;
          if (cnt == 3'd1) lo_q <= mem_rdata;
          if (cnt == 3'd2) hi_q <= mem_rdata;
          if (cnt == CNT_W'(RET_LEN - 1)) begin
            pc_r  <= {hi_q, lo_q};
            psw_r <= mem_rdata;
            sp_r  <= sp_r + 16'd3;
            if (ret_kind_q) nmi_r <= 1'b0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign pc_q       = pc_r;
  assign sp_q       = sp_r;
  assign st_q       = psw_r;
  assign seq_busy   = !idle;
  assign nmi_active = nmi_r;

  // R2
  start_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(insn_done || ret_go));
  // R4
  imf_off_in_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (seq_busy && !st_q[IMF_BIT]));
  // R6
  push_sp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_ENTRY && cnt == 3'd2) |=> (sp_q == $past(sp_q) - 16'd3));
  // R9
  pop_sp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RET && cnt == 3'd3) |=> (sp_q == $past(sp_q) + 16'd3));
  // R6
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: tb/tb_intr_accept_seq.sv
module tb_intr_accept_seq;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, irq_clr = '0, irq_pend;
  logic insn_done = 0, ret_go = 0, ret_nmi = 0;
  logic [15:0] mem_addr, pc_wdata = '0, sp_wdata = '0, pc_q, sp_q;
  logic mem_we, mem_re, pc_load = 0, sp_load = 0, st_load = 0, seq_busy, nmi_active;
  logic [7:0] mem_wdata, mem_rdata = '0, st_wdata = '0, st_q;
  logic [7:0] mem [512];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  intr_accept_seq dut (.*);

  function automatic int ix(input logic [15:0] a);
    return {23'd0, a[15], a[7:0]};
  endfunction
  function automatic logic [15:0] vec(input int k);
    return {8'(8'hD2 + k), 8'(8'h03 + k * 16)};
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[ix(mem_addr)] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[ix(mem_addr)];
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [N-1:0] r, input logic [N-1:0] c);
    @(negedge clk); irq_req = r; irq_clr = c;
    @(negedge clk); irq_req = '0; irq_clr = '0;
  endtask

  task automatic load_regs(input logic [15:0] pc, input logic [15:0] sp, input logic [7:0] st);
    @(negedge clk); pc_load = 1; sp_load = 1; st_load = 1;
    pc_wdata = pc; sp_wdata = sp; st_wdata = st;
    @(negedge clk); pc_load = 0; sp_load = 0; st_load = 0;
  endtask

  // strobe insn_done (or ret_go), return number of busy cycles;
  // optionally drive loads in busy cycle 1 (R11)
  task automatic run_seq(input bit is_ret, input bit kind, input bit poke, output int n,
                         output logic [7:0] st0, output logic [N-1:0] pend0);
    @(negedge clk);
    if (is_ret) begin ret_go = 1; ret_nmi = kind; end else insn_done = 1;
    @(negedge clk); ret_go = 0; ret_nmi = 0; insn_done = 0;
    st0 = st_q; pend0 = irq_pend; n = 0;
    while (seq_busy && n < 20) begin
      n++;
      if (poke && n == 2) begin pc_load = 1; pc_wdata = 16'hAAAA; sp_load = 1; sp_wdata = 16'h0055; end
      else begin pc_load = 0; sp_load = 0; end
      @(negedge clk);
    end
    pc_load = 0; sp_load = 0;
  endtask

  task automatic t_reset();
    chk("R8 pc", pc_q, 0); chk("R8 sp", sp_q, 0); chk("R8 st", {8'd0, st_q}, 0);
    chk("R8 pend", {8'd0, irq_pend}, 0); chk("R8 busy", {15'd0, seq_busy}, 0);
    chk("R8 nmi", {15'd0, nmi_active}, 0);
  endtask

  task automatic t_latch();
    int n; logic [7:0] s; logic [N-1:0] p;
    pulse_req(8'h08, 8'h00);
    chk("R1 set", {8'd0, irq_pend}, 16'h0008);
    run_seq(0, 0, 0, n, s, p);
    chk("R2 masked no start", 16'(n), 0);
    chk("R1 held", {8'd0, irq_pend}, 16'h0008);
    pulse_req(8'h08, 8'h08);
    chk("R1 set beats clear", {8'd0, irq_pend}, 16'h0008);
    pulse_req(8'h00, 8'h08);
    chk("R1 sw clear", {8'd0, irq_pend}, 0);
  endtask

  task automatic t_entry();
    int n; logic [7:0] s; logic [N-1:0] p;
    load_regs(16'h1234, 16'h00F0, 8'h95);
    pulse_req(8'h24, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 no boundary no start", {15'd0, seq_busy}, 0);
    run_seq(0, 0, 1, n, s, p);
    chk("R3 entry length", 16'(n), 8);
    chk("R4 imf off", {15'd0, s[7]}, 0);
    chk("R5 other latch kept", {8'd0, p}, 16'h0020);
    chk("R6 push st", {8'd0, mem[ix(16'h00F0)]}, 16'h0095);
    chk("R6 push pch", {8'd0, mem[ix(16'h00EF)]}, 16'h0012);
    chk("R6 push pcl", {8'd0, mem[ix(16'h00EE)]}, 16'h0034);
    chk("R6 sp", sp_q, 16'h00ED);
    chk("R7 pc vector", pc_q, vec(2));
    chk("R11 pc load ignored", pc_q, vec(2));
    chk("R11 sp load ignored", sp_q, 16'h00ED);
    chk("R4 status after", {8'd0, st_q}, 16'h0015);
  endtask

  task automatic t_return_prio();
    int n; logic [7:0] s; logic [N-1:0] p;
    run_seq(1, 0, 0, n, s, p);
    chk("R9 ret length", 16'(n), 4);
    chk("R9 pc", pc_q, 16'h1234); chk("R9 sp", sp_q, 16'h00F0);
    chk("R9 st imf back", {8'd0, st_q}, 16'h0095);
    pulse_req(8'h50, 8'h00);
    run_seq(0, 0, 0, n, s, p);
    chk("R2 lowest wins", pc_q, vec(4));
    chk("R5 others kept", {8'd0, irq_pend}, 16'h0060);
    run_seq(1, 0, 0, n, s, p);
    run_seq(0, 0, 0, n, s, p);
    chk("R2 next lowest", pc_q, vec(5));
    chk("R5 last kept", {8'd0, irq_pend}, 16'h0040);
    run_seq(1, 0, 0, n, s, p);
    pulse_req(8'h00, 8'h40);
  endtask

  task automatic t_nmi();
    int n; logic [7:0] s; logic [N-1:0] p;
    load_regs(16'h1234, 16'h00F0, 8'h00);
    pulse_req(8'h01, 8'h00);
    run_seq(0, 0, 0, n, s, p);
    chk("R10 nmi ignores imf", pc_q, vec(0));
    chk("R10 nmi active", {15'd0, nmi_active}, 1);
    pulse_req(8'h01, 8'h00);
    run_seq(0, 0, 0, n, s, p);
    chk("R10 no nesting", 16'(n), 0);
    run_seq(1, 0, 0, n, s, p);
    chk("R10 maskable ret keeps flag", {15'd0, nmi_active}, 1);
    chk("R9 pc back", pc_q, 16'h1234);
    run_seq(0, 0, 0, n, s, p);
    chk("R10 still blocked", 16'(n), 0);
    load_regs(16'h0000, 16'h00ED, 8'h00);
    run_seq(1, 1, 0, n, s, p);
    chk("R10 nmi ret clears", {15'd0, nmi_active}, 0);
    run_seq(0, 0, 0, n, s, p);
    chk("R10 nmi accepted again", pc_q, vec(0));
    chk("R3 nmi entry length", 16'(n), 8);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    for (int k = 0; k < N; k++) begin
      mem[ix(16'hFFF0 + 16'(2 * k))]     = vec(k)[7:0];
      mem[ix(16'hFFF0 + 16'(2 * k + 1))] = vec(k)[15:8];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_entry();
    t_return_prio();
    t_nmi();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule